// File: doc/BRIEF.md
# Quad depth test unit

This block runs the depth comparison for a group of four fragments in a single pass. For each lane it receives three inputs: the fragment depth, already converted to unsigned fixed point; the 32-bit depth/stencil word currently held for that pixel; and one coverage bit. The depth field of the stored word is its low 24 bits, and the upper byte holds the stencil value.

A configured compare function decides whether each lane passes. A lane's coverage bit is cleared when it fails. When depth writes are enabled, every lane that is still covered gets a new write-back word: its stored depth is replaced by the fragment depth and its stencil byte is kept. Lanes that are not covered hand back their original word.

The compare function and the write enable are sampled into configuration registers on every clock. A quad is accepted through a valid/ready handshake, and its result appears one cycle later in an output register that holds under backpressure.

Top module: `quad_depth_test`

## Requirements
- R1: After reset, `out_valid` and `out_mask` are 0 and `in_ready` is 1.
- R2: Function code 0 (never) clears all four result lanes. Code 7 (always) returns the input mask unchanged.
- R3: Code 1 (less) passes a lane when frag < stored. Code 4 (greater) passes a lane when frag > stored. Both are unsigned 24-bit compares, so 0x800000 is greater than 0x7FFFFF.
- R4: Code 2 (equal) passes a lane when frag == stored. Code 5 (not-equal) passes a lane when they differ.
- R5: Code 3 (less-or-equal) passes a lane unless frag > stored. Code 6 (greater-or-equal) passes a lane unless stored > frag.
- R6: Only bits 23:0 of each stored word take part in the compare. The stencil bits 31:24 are ignored.
- R7: With write enable set, lane i of `out_word` is {stored[31:24], frag} where the result mask bit is 1, and the stored word where it is 0. Lane i occupies bits 32*i+31:32*i.
- R8: With write enable clear, `out_word` equals the stored words unchanged.
- R9: A lane whose input mask bit is 0 has result bit 0 under every function.
- R10: A quad accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that edge.
- R11: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the outputs hold.
- R12: The function and write enable are registered. A quad accepted on the same edge on which the configuration inputs change is processed with the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_func | input | 3 | Compare function code |
| cfg_wr_en | input | 1 | Depth write enable |
| in_valid | input | 1 | Quad present |
| in_ready | output | 1 | Quad accepted this cycle |
| in_frag_z | input | LANES*ZW | Fragment depths, lane 0 lowest |
| in_stored | input | LANES*WW | Stored depth/stencil words |
| in_mask | input | LANES | Input coverage |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_mask | output | LANES | Result coverage |
| out_word | output | LANES*WW | Write-back words |

## Verification
The bench keeps the default parameters: four lanes, a 24-bit depth field and 32-bit words. With these defaults one quad can hold an equal, a less and a greater lane at the same time, so a single data pattern separates all eight functions. The full-scale depth 0xFFFFFF sits under a nonzero stencil byte, which checks that the stencil bits are kept out of the compare. The pair 0x800000 and 0x7FFFFF exercises the top bit of the depth field in the unsigned compare.

// File: rtl/quad_depth_test.sv
module quad_depth_test #(
  parameter int LANES = 4,
  parameter int ZW = 24,
  parameter int WW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cfg_func,
  input  logic               cfg_wr_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LANES*ZW-1:0] in_frag_z,
  input  logic [LANES*WW-1:0] in_stored,
  input  logic [LANES-1:0]   in_mask,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LANES-1:0]   out_mask,
  output logic [LANES*WW-1:0] out_word
);
  localparam int SW = WW - ZW;
  localparam logic [2:0] F_NEVER = 3'd0, F_LESS = 3'd1, F_EQUAL = 3'd2, F_LEQUAL = 3'd3,
                         F_GREATER = 3'd4, F_NOTEQUAL = 3'd5, F_GEQUAL = 3'd6, F_ALWAYS = 3'd7;

  logic [2:0]          func_q;
  logic                we_q;
  logic                accept;
  logic [LANES-1:0]    nxt_mask;
  logic [LANES*WW-1:0] nxt_word;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= F_ALWAYS;
      we_q   <= 1'b0;
    end else begin
      func_q <= cfg_func;
      we_q   <= cfg_wr_en;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ZW-1:0] fz, sz;
    logic [SW-1:0] st;
    logic eq, gt, lt, pass;
    assign fz = in_frag_z[i*ZW +: ZW];
    assign sz = in_stored[i*WW +: ZW];
    assign st = in_stored[i*WW+ZW +: SW];
    assign eq = (fz == sz);
    assign gt = (fz > sz);
    assign lt = (sz > fz);
    always_comb begin
      case (func_q)
        F_NEVER:    pass = 1'b0;
        F_LESS:     pass = lt;
        F_EQUAL:    pass = eq;
        F_LEQUAL:   pass = !gt;
        F_GREATER:  pass = gt;
        F_NOTEQUAL: pass = !eq;
        F_GEQUAL:   pass = !lt;
        default:    pass = 1'b1;
      endcase
    end
    assign nxt_mask[i] = in_mask[i] & pass;
    assign nxt_word[i*WW +: WW] = (we_q && nxt_mask[i]) ? {st, fz} : in_stored[i*WW +: WW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_word  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_mask  <= nxt_mask;
      out_word  <= nxt_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_depth_test_chk.sv
module quad_depth_test_chk #(
  parameter int LANES = 4,
  parameter int ZW = 24,
  parameter int WW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [LANES*WW-1:0] in_stored,
  input logic [LANES-1:0]   in_mask,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LANES-1:0]   out_mask,
  input logic [LANES*WW-1:0] out_word,
  input logic [2:0]         func_q,
  input logic               we_q
);
  localparam int SW = WW - ZW;
  logic acc;
  assign acc = in_valid && in_ready;

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n) acc |=> out_valid);
  a_r9_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((out_mask & ~$past(in_mask)) == '0));
  a_r2_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && func_q == 3'd0) |=> (out_mask == '0));
  a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !we_q) |=> (out_word == $past(in_stored)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_mask)));
  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  for (genvar i = 0; i < LANES; i++) begin : g_st
    a_r7_stencil_kept: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (out_word[i*WW+ZW +: SW] == $past(in_stored[i*WW+ZW +: SW])));
  end
endmodule

bind quad_depth_test quad_depth_test_chk #(.LANES(LANES), .ZW(ZW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_stored(in_stored), .in_mask(in_mask), .out_valid(out_valid),
  .out_ready(out_ready), .out_mask(out_mask), .out_word(out_word),
  .func_q(func_q), .we_q(we_q));

// File: tb/quad_depth_test_bench.sv
module quad_depth_test_bench;
  localparam int L = 4, ZW = 24, WW = 32;

  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_func = 3'd7;
  logic cfg_wr_en = 0, in_valid = 0, out_ready = 1;
  logic in_ready, out_valid;
  logic [L*ZW-1:0] in_frag_z = '0;
  logic [L*WW-1:0] in_stored = '0, out_word;
  logic [L-1:0] in_mask = '0, out_mask;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  quad_depth_test u_quad_depth_test (.*);

  typedef struct packed {
    logic [2:0] func;
    logic       we;
    logic [3:0] mask;
    logic [3:0] exp;
  } vec_t;

  // lanes: 0 equal, 1 frag<stored, 2 frag>stored, 3 equal at full scale under stencil 0xD4
  localparam logic [L*ZW-1:0] FZ = {24'hFFFFFF, 24'h000400, 24'h000100, 24'h000100};
  localparam logic [L*WW-1:0] SD = {32'hD4FFFFFF, 32'hC3000300, 32'hB2000200, 32'hA1000100};

  localparam vec_t VECS [0:11] = '{
    '{3'd0, 1'b1, 4'b1111, 4'b0000},   // R2 never
    '{3'd1, 1'b1, 4'b1111, 4'b0010},   // R3 less
    '{3'd2, 1'b0, 4'b1111, 4'b1001},   // R4 equal, R6 stencil ignored on lane 3
    '{3'd3, 1'b1, 4'b1111, 4'b1011},   // R5 lequal
    '{3'd4, 1'b0, 4'b1111, 4'b0100},   // R3 greater
    '{3'd5, 1'b1, 4'b1111, 4'b0110},   // R4 notequal
    '{3'd6, 1'b1, 4'b1111, 4'b1101},   // R5 gequal
    '{3'd7, 1'b1, 4'b1111, 4'b1111},   // R2 always
    '{3'd7, 1'b1, 4'b1010, 4'b1010},   // R2 always keeps partial mask
    '{3'd3, 1'b1, 4'b0101, 4'b0001},   // R9 masked lanes stay off
    '{3'd4, 1'b1, 4'b1011, 4'b0000},   // R9
    '{3'd2, 1'b1, 4'b1111, 4'b1001}    // R6, R7
  };

  function automatic string req_of(logic [2:0] f);
    case (f)
      3'd0, 3'd7: return "R2";
      3'd1, 3'd4: return "R3";
      3'd2, 3'd5: return "R4/R6";
      default:    return "R5";
    endcase
  endfunction

  function automatic logic [L*WW-1:0] exp_word(logic we, logic [L-1:0] m,
                                               logic [L*ZW-1:0] fz, logic [L*WW-1:0] sd);
    logic [L*WW-1:0] w = sd;
    for (int i = 0; i < L; i++)
      if (we && m[i]) w[i*WW +: ZW] = fz[i*ZW +: ZW];
    return w;
  endfunction

  task automatic check(string req, logic [L*WW-1:0] act, logic [L*WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic [2:0] f, logic we, logic [L-1:0] m, logic [L*ZW-1:0] fz,
                     logic [L*WW-1:0] sd, logic [L-1:0] em, string req);
    @(negedge clk); cfg_func = f; cfg_wr_en = we; in_valid = 0;
    @(negedge clk); in_valid = 1; in_mask = m; in_frag_z = fz; in_stored = sd;
    @(negedge clk); in_valid = 0;
    check({req, " R10 valid"}, {{(L*WW-1){1'b0}}, out_valid}, 1);
    check({req, " mask"}, {{(L*WW-L){1'b0}}, out_mask}, {{(L*WW-L){1'b0}}, em});
    check({req, we ? " R7 word" : " R8 word"}, out_word, exp_word(we, em, fz, sd));
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {{(L*WW-1){1'b0}}, out_valid}, 0);
    check("R1 out_mask", {{(L*WW-L){1'b0}}, out_mask}, 0);
    check("R1 in_ready", {{(L*WW-1){1'b0}}, in_ready}, 1);
    rst_n = 1;

    foreach (VECS[k])
      run(VECS[k].func, VECS[k].we, VECS[k].mask, FZ, SD, VECS[k].exp, req_of(VECS[k].func));

    // R3 unsigned compare at the top bit of the depth field
    run(3'd4, 1'b1, 4'b1111, {4{24'h800000}}, {4{32'hFF7FFFFF}}, 4'b1111, "R3 msb");
    run(3'd1, 1'b1, 4'b1111, {4{24'h800000}}, {4{32'hFF7FFFFF}}, 4'b0000, "R3 msb less");

    // R12: config change on the accepting edge uses the previous setting (always)
    @(negedge clk); cfg_func = 3'd7; cfg_wr_en = 0;
    @(negedge clk); cfg_func = 3'd0; in_valid = 1; in_mask = 4'b1111;
    in_frag_z = FZ; in_stored = SD;
    @(negedge clk); in_valid = 0;
    check("R12 old func", {{(L*WW-L){1'b0}}, out_mask}, {{(L*WW-L){1'b0}}, 4'b1111});
    check("R12 old we", out_word, SD);

    // R11 backpressure
    @(negedge clk); cfg_func = 3'd2; cfg_wr_en = 1; out_ready = 0;
    @(negedge clk); in_valid = 1; in_mask = 4'b1111; in_frag_z = FZ; in_stored = SD;
    @(negedge clk); in_frag_z = {4{24'h000001}}; in_stored = {4{32'h00000001}}; in_mask = 4'b0011;
    check("R11 stall ready", {{(L*WW-1){1'b0}}, in_ready}, 0);
    check("R11 first mask", {{(L*WW-L){1'b0}}, out_mask}, {{(L*WW-L){1'b0}}, 4'b1001});
    @(negedge clk);
    check("R11 hold word", out_word, exp_word(1'b1, 4'b1001, FZ, SD));
    check("R11 hold valid", {{(L*WW-1){1'b0}}, out_valid}, 1);
    out_ready = 1;
    @(negedge clk); in_valid = 0;
    check("R11 second mask", {{(L*WW-L){1'b0}}, out_mask}, {{(L*WW-L){1'b0}}, 4'b0011});
    check("R11 second word", out_word, {{2{32'h00000001}}, {2{32'h00000001}}});
    @(negedge clk);
    check("R10 drain", {{(L*WW-1){1'b0}}, out_valid}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule